// File: doc/BRIEF.md
# Serial FIFO Interrupt Control Unit

This block holds the control register and the sticky status flags behind the interrupt requests of a FIFO-buffered serial port. It watches the fill counts of the transmit and receive FIFOs against their programmed trigger levels, and it latches single-cycle error and break pulses from the receiver. It raises four registered interrupt requests: transmit-empty, receive-full, receive-error and break. It also drives the transmitter enable, the receiver enable and the two clock-select bits to the rest of the port.

Software reaches the block through a simple register bus. Address 0 is the control register and address 1 is the status register. A flag clears only through a handshake. Software must first read the status register while that flag is 1, and then write 0 to the flag's bit. For the two FIFO flags, the write is also refused while the FIFO level is still on the side of the threshold that set the flag. When a flag condition arrives in the same cycle as a clear, the flag stays set, so no event is lost.

Top module: `sfifo_irq_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00, and all four interrupt outputs are 0.
- R2: Control register (address 0) bit positions are as follows. Bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable, bit 5 the transmitter enable (`tx_en`), bit 4 the receiver enable (`rx_en`), and bits 1:0 the clock select (`clk_sel`). Bits 3:2 always read 0 and ignore writes, so writing 0xFF reads back 0xF3.
- R3: While `standby` is 1 at a clock edge, the control register returns to 0x00 at that edge, and a write in the same cycle is overridden.
- R4: Status bit 0 (transmit-empty) sets at the edge after `tx_count < tx_trig`. `irq_txe` is this flag ANDed with control bit 7.
- R5: Writing 0 to a status bit clears the flag only if the flag is armed. A flag is armed when a status read returned 1 for it since the last status-register write. Every status write disarms all flags. Writing 1 to a status bit has no effect.
- R6: A permitted clear of the transmit-empty flag takes effect only while `tx_count > tx_trig`. At or below the trigger, the flag stays set.
- R7: Status bit 1 (receive-full) sets at the edge after `rx_count >= rx_trig`. `irq_rxf` is this flag ANDed with control bit 6.
- R8: A permitted clear of the receive-full flag takes effect only while `rx_count < rx_trig`.
- R9: A one-cycle pulse on `rx_err_pulse` sets status bit 2, and a pulse on `rx_brk_pulse` sets status bit 3. Each flag stays set until cleared through the handshake. `irq_err` and `irq_brk` are these flags ANDed with control bit 6.
- R10: Clearing control bit 6 drops `irq_err`, `irq_brk` and `irq_rxf`, and clearing bit 7 drops `irq_txe`. The status flags themselves are kept.
- R11: Each interrupt output changes exactly one clock edge after the flag or enable bit that drives it changes.
- R12: A flag set condition in the same cycle as a permitted clear wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Standby entry; clears the control register |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flags read as 1) |
| bus_addr | input | ADDR_W (2) | Register address: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| tx_count | input | CNT_W (5) | Transmit FIFO entries |
| tx_trig | input | CNT_W (5) | Transmit trigger level |
| rx_count | input | CNT_W (5) | Receive FIFO entries |
| rx_trig | input | CNT_W (5) | Receive trigger level |
| rx_err_pulse | input | 1 | One-cycle receive error event |
| rx_brk_pulse | input | 1 | One-cycle break event |
| irq_txe | output | 1 | Transmit-empty request |
| irq_rxf | output | 1 | Receive-full request |
| irq_err | output | 1 | Receive-error request |
| irq_brk | output | 1 | Break request |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| clk_sel | output | 2 | Clock source select |

## Verification
Each result has a fixed due time, counted from the clock edge that captures a stimulus:
- Control outputs (`tx_en`, `rx_en`, `clk_sel`) and the status flags change at that edge.
- Interrupt outputs change one edge later.
- Read data is valid in the same cycle as the read strobe.

The driver tasks tag every expected interrupt or control value with its due cycle, one or two edges ahead. The monitor compares it shortly after exactly that edge. For the latency requirement, the monitor also checks that the output has not yet moved one edge earlier. Refused and accepted clears are told apart by driving the FIFO count to below, equal to and above each trigger level.

// File: rtl/sfic_pkg.sv
// Package: register layout constants and the control-register type shared
// by the serial FIFO interrupt control unit.
package sfic_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned NUM_FLAGS = 4;

    // Flag order inside the status register (bit index = enum value)
    typedef enum logic [1:0] {
        FLG_TXE = 2'd0,
        FLG_RXF = 2'd1,
        FLG_ERR = 2'd2,
        FLG_BRK = 2'd3
    } flag_idx_e;

    // Writable bits of the control register; bits 3:2 are reserved
    localparam logic [DATA_W-1:0] CTRL_WMASK = 8'hF3;

    typedef struct packed {
        logic       tie;   // transmit interrupt enable
        logic       rie;   // receive interrupt enable
        logic       te;    // transmitter enable
        logic       re;    // receiver enable
        logic [1:0] cks;   // clock source select
    } ctrl_t;

endpackage

// File: rtl/sfic_ctrl_reg.sv
// Module: control register.
// Holds the masked control byte and splits it into named fields.
// Assumes: standby has priority over a write in the same cycle; reserved
// bits are masked on write so they always read back as zero.
module sfic_ctrl_reg
    import sfic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] raw_o,
    output ctrl_t             cfg_o
);

    logic [DATA_W-1:0] reg_q;

    // Capture masked write data; reset and standby both clear the byte
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) begin
            reg_q <= '0;
        end else if (wr_i) begin
            reg_q <= wdata_i & CTRL_WMASK;
        end
    end

    // Decode the stored byte into fields
    always_comb begin
        cfg_o.tie = reg_q[7];
        cfg_o.rie = reg_q[6];
        cfg_o.te  = reg_q[5];
        cfg_o.re  = reg_q[4];
        cfg_o.cks = reg_q[1:0];
        raw_o     = reg_q;
    end

endmodule

// File: rtl/sfic_flag_cell.sv
// Module: one sticky status flag with its read-then-write-zero handshake.
// The flag sets on set_i and clears when a status write carries 0 in its
// bit, the flag is armed and clr_ok_i allows it. A set in the same cycle wins.
// Assumes: rd_hit_i / wr_hit_i are already qualified by the status address.
module sfic_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_ok_i,
    input  logic rd_hit_i,
    input  logic wr_hit_i,
    input  logic wbit_i,
    output logic flag_o,
    output logic armed_o
);

    logic flag_q;
    logic armed_q;
    logic clear_now;

    // A clear is permitted only after an armed read and when the level allows
    always_comb begin
        clear_now = wr_hit_i && !wbit_i && armed_q && clr_ok_i;
    end

    // Flag register: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clear_now) begin
            flag_q <= 1'b0;
        end
    end

    // Arm on a read that sees 1; any status write disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_hit_i) begin
            armed_q <= 1'b0;
        end else if (rd_hit_i && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o  = flag_q;
    assign armed_o = armed_q;

endmodule

// File: rtl/sfic_irq_regs.sv
// Module: registered interrupt outputs, one per flag.
// Each request is the flag ANDed with its enable, registered once so that
// the output moves exactly one edge after either input moves.
module sfic_irq_regs #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] irq_o
);

    logic [N-1:0] irq_q;

    // Register the gated requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= flag_i & en_i;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/sfifo_irq_ctrl.sv
// Module: serial FIFO interrupt control unit (top).
// Decodes the register bus, derives set and clear-permit conditions from
// the FIFO fill levels and event pulses, keeps one flag cell per status bit,
// and registers the four interrupt requests.
// Assumes: address 0 is control, address 1 is status; other addresses read
// zero and ignore writes. FIFO counts and triggers are in entries.
module sfifo_irq_ctrl
    import sfic_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 2,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  tx_trig,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic              rx_err_pulse,
    input  logic              rx_brk_pulse,
    output logic              irq_txe,
    output logic              irq_rxf,
    output logic              irq_err,
    output logic              irq_brk,
    output logic              tx_en,
    output logic              rx_en,
    output logic [1:0]        clk_sel
);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

    logic                 ctrl_wr;
    logic                 stat_wr;
    logic                 stat_rd;
    logic [DATA_W-1:0]    ctrl_raw;
    ctrl_t                cfg;
    logic                 tie_w;
    logic                 rie_w;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] ok_vec;
    logic [NUM_FLAGS-1:0] en_vec;
    logic [NUM_FLAGS-1:0] flags_w;
    logic [NUM_FLAGS-1:0] armed_w;
    logic [NUM_FLAGS-1:0] irq_w;

    // Address decode of the register bus
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
        stat_wr = bus_wr && (bus_addr == ADDR_STAT);
        stat_rd = bus_rd && (bus_addr == ADDR_STAT);
    end

    sfic_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby),
        .wr_i      (ctrl_wr),
        .wdata_i   (bus_wdata),
        .raw_o     (ctrl_raw),
        .cfg_o     (cfg)
    );

    // Set conditions, clear permits and interrupt enables per flag
    always_comb begin
        tie_w = cfg.tie;
        rie_w = cfg.rie;

        set_vec[FLG_TXE] = (tx_count < tx_trig);
        ok_vec[FLG_TXE]  = (tx_count > tx_trig);
        en_vec[FLG_TXE]  = tie_w;

        set_vec[FLG_RXF] = (rx_count >= rx_trig);
        ok_vec[FLG_RXF]  = (rx_count < rx_trig);
        en_vec[FLG_RXF]  = rie_w;

        set_vec[FLG_ERR] = rx_err_pulse;
        ok_vec[FLG_ERR]  = 1'b1;
        en_vec[FLG_ERR]  = rie_w;

        set_vec[FLG_BRK] = rx_brk_pulse;
        ok_vec[FLG_BRK]  = 1'b1;
        en_vec[FLG_BRK]  = rie_w;
    end

    // One handshake cell per status bit
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sfic_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_vec[g]),
            .clr_ok_i (ok_vec[g]),
            .rd_hit_i (stat_rd),
            .wr_hit_i (stat_wr),
            .wbit_i   (bus_wdata[g]),
            .flag_o   (flags_w[g]),
            .armed_o  (armed_w[g])
        );
    end

    sfic_irq_regs #(.N(NUM_FLAGS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flags_w),
        .en_i   (en_vec),
        .irq_o  (irq_w)
    );

    // Read data multiplexer
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_raw;
            ADDR_STAT: bus_rdata = {{(DATA_W - NUM_FLAGS){1'b0}}, flags_w};
            default:   bus_rdata = '0;
        endcase
    end

    // Output mapping
    always_comb begin
        irq_txe = irq_w[FLG_TXE];
        irq_rxf = irq_w[FLG_RXF];
        irq_err = irq_w[FLG_ERR];
        irq_brk = irq_w[FLG_BRK];
        tx_en   = cfg.te;
        rx_en   = cfg.re;
        clk_sel = cfg.cks;
    end

endmodule

// File: rtl/sfic_checker.sv
// Module: property checker for the serial FIFO interrupt control unit,
// attached to the top module by bind.
module sfic_checker #(
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  tx_trig,
    input logic [CNT_W-1:0]  rx_count,
    input logic [CNT_W-1:0]  rx_trig,
    input logic              rx_err_pulse,
    input logic [3:0]        flags_w,
    input logic [3:0]        armed_w,
    input logic              tie_w,
    input logic              rie_w,
    input logic              irq_txe,
    input logic              irq_err,
    input logic              irq_brk,
    input logic              tx_en,
    input logic              rx_en,
    input logic [1:0]        clk_sel
);

    logic past_ok;

    // Marks the cycles where $past has a post-reset history
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == '0) |-> (bus_rdata[3:2] == 2'b00));

    p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!tx_en && !rx_en && clk_sel == 2'b00));

    p_txe_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count < tx_trig) |=> flags_w[0]);

    p_noarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_w[0] && !armed_w[0]) |=> flags_w[0]);

    p_txe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_w[0] && !(tx_count > tx_trig)) |=> flags_w[0]);

    p_rxf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= rx_trig) |=> flags_w[1]);

    p_rxf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_w[1] && (rx_count >= rx_trig)) |=> flags_w[1]);

    p_rie_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rie_w |=> (!irq_err && !irq_brk));

    p_txe_lat_r11: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        irq_txe == $past(flags_w[0] && tie_w));

    p_err_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_pulse |=> flags_w[2]);

endmodule

bind sfifo_irq_ctrl sfic_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby      (standby),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .tx_count     (tx_count),
    .tx_trig      (tx_trig),
    .rx_count     (rx_count),
    .rx_trig      (rx_trig),
    .rx_err_pulse (rx_err_pulse),
    .flags_w      (flags_w),
    .armed_w      (armed_w),
    .tie_w        (tie_w),
    .rie_w        (rie_w),
    .irq_txe      (irq_txe),
    .irq_err      (irq_err),
    .irq_brk      (irq_brk),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .clk_sel      (clk_sel)
);

// File: tb/sim_sfifo_irq_ctrl.sv
`timescale 1ns/100ps
module sim_sfifo_irq_ctrl;

    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          standby = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [CW-1:0] tx_count = CW'(8);
    logic [CW-1:0] tx_trig  = CW'(4);
    logic [CW-1:0] rx_count = CW'(0);
    logic [CW-1:0] rx_trig  = CW'(8);
    logic          rx_err_pulse = 1'b0;
    logic          rx_brk_pulse = 1'b0;
    logic          irq_txe, irq_rxf, irq_err, irq_brk, tx_en, rx_en;
    logic [1:0]    clk_sel;

    sfifo_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_count(tx_count), .tx_trig(tx_trig),
        .rx_count(rx_count), .rx_trig(rx_trig),
        .rx_err_pulse(rx_err_pulse), .rx_brk_pulse(rx_brk_pulse),
        .irq_txe(irq_txe), .irq_rxf(irq_rxf), .irq_err(irq_err),
        .irq_brk(irq_brk), .tx_en(tx_en), .rx_en(rx_en), .clk_sel(clk_sel)
    );

    always #2.5 clk = ~clk;

    // Output selectors for the scoreboard
    localparam int S_TXE = 0, S_RXF = 1, S_ERR = 2, S_BRK = 3,
                   S_TXEN = 4, S_RXEN = 5, S_CKS = 6;

    typedef struct {
        int    id;
        int    exp;
        int    due;
        string req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Edge counter used for due times
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int get_sig(int id);
        case (id)
            S_TXE:   return int'(irq_txe);
            S_RXF:   return int'(irq_rxf);
            S_ERR:   return int'(irq_err);
            S_BRK:   return int'(irq_brk);
            S_TXEN:  return int'(tx_en);
            S_RXEN:  return int'(rx_en);
            default: return int'(clk_sel);
        endcase
    endfunction

    task automatic check(int got, int exp, string req);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    // Monitor: compare every queued item just after its due edge
    always begin
        @(posedge clk);
        #1;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                check(get_sig(sb[i].id), sb[i].exp, sb[i].req);
                sb.delete(i);
            end
        end
    end

    task automatic push(int id, int exp, int dly, string req);
        item_t it;
        it.id = id; it.exp = exp; it.due = cyc + dly; it.req = req;
        sb.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, int exp, string req);
        bus_addr = 2'(a); bus_rd = 1'b1;
        #1;
        check(int'(bus_rdata), exp, req);
        step();
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, 8'h00, "R1 control");
        rd(1, 8'h00, "R1 status");
        check(int'({irq_txe, irq_rxf, irq_err, irq_brk}), 0, "R1 irqs");

        // R2: layout and reserved bits
        push(S_TXEN, 1, 1, "R2 tx_en"); push(S_RXEN, 1, 1, "R2 rx_en");
        push(S_CKS, 3, 1, "R2 clk_sel");
        wr(0, 8'hFF);
        rd(0, 8'hF3, "R2 reserved bits");
        push(S_TXEN, 0, 1, "R2 te only"); push(S_RXEN, 1, 1, "R2 re only");
        push(S_CKS, 2, 1, "R2 cks");
        wr(0, 8'h12);

        // R3: standby clears control, even against a write
        push(S_TXEN, 0, 1, "R3 tx_en"); push(S_RXEN, 0, 1, "R3 rx_en");
        push(S_CKS, 0, 1, "R3 clk_sel");
        standby = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hFF; bus_wr = 1'b1;
        step();
        standby = 1'b0; bus_wr = 1'b0;
        rd(0, 8'h00, "R3 control");
        wr(0, 8'hC0);

        // R4/R11: transmit-empty sets, irq one edge after flag
        tx_count = CW'(3);
        push(S_TXE, 0, 1, "R11 txe not early");
        push(S_TXE, 1, 2, "R4 irq_txe");
        idle(2);
        tx_count = CW'(6);
        idle(1);
        // R5: write 0 without arming read is ignored
        push(S_TXE, 1, 2, "R5 unarmed clear ignored");
        wr(1, 8'h00);
        rd(1, 8'h01, "R5 flag kept");
        // R5: write 1 has no effect and disarms
        wr(1, 8'hFF);
        push(S_TXE, 1, 2, "R5 disarmed by write");
        wr(1, 8'h00);
        rd(1, 8'h01, "R5 still set");
        // R6: at trigger level the clear is refused
        tx_count = CW'(4);
        push(S_TXE, 1, 2, "R6 refused at trigger");
        wr(1, 8'hFE);
        rd(1, 8'h01, "R6 flag kept");
        // R6/R11: above trigger the clear works
        tx_count = CW'(5);
        push(S_TXE, 1, 1, "R11 txe fall latency");
        push(S_TXE, 0, 2, "R6 cleared above trigger");
        wr(1, 8'hFE);
        rd(1, 8'h00, "R6 status clear");

        // R10: clearing transmit enable drops irq, keeps flag
        tx_count = CW'(2);
        idle(2);
        push(S_TXE, 1, 1, "R10 txe before drop");
        push(S_TXE, 0, 2, "R10 txe gated");
        wr(0, 8'h40);
        rd(1, 8'h01, "R10 flag kept");
        tx_count = CW'(8);
        wr(1, 8'hFE);
        wr(0, 8'hC0);
        rd(1, 8'h00, "R6 cleanup");

        // R7/R8: receive-full
        rx_count = CW'(8);
        push(S_RXF, 0, 1, "R11 rxf not early");
        push(S_RXF, 1, 2, "R7 irq_rxf");
        idle(2);
        rd(1, 8'h02, "R7 status");
        push(S_RXF, 1, 2, "R8 refused at trigger");
        wr(1, 8'hFD);
        rx_count = CW'(7);
        rd(1, 8'h02, "R8 flag kept");
        push(S_RXF, 0, 2, "R8 cleared below trigger");
        wr(1, 8'hFD);
        rd(1, 8'h00, "R8 status clear");

        // R9: sticky error and break flags
        push(S_ERR, 1, 2, "R9 irq_err");
        rx_err_pulse = 1'b1; step(); rx_err_pulse = 1'b0;
        idle(3);
        rd(1, 8'h04, "R9 err sticky");
        push(S_BRK, 1, 2, "R9 irq_brk");
        rx_brk_pulse = 1'b1; step(); rx_brk_pulse = 1'b0;
        idle(2);
        // R10: receive enable gates error and break
        push(S_ERR, 0, 2, "R10 err gated");
        push(S_BRK, 0, 2, "R10 brk gated");
        wr(0, 8'h80);
        rd(1, 8'h0C, "R10 flags kept");
        push(S_ERR, 1, 2, "R10 err regated");
        wr(0, 8'hC0);
        push(S_ERR, 0, 2, "R9 err cleared");
        push(S_BRK, 0, 2, "R9 brk cleared");
        wr(1, 8'hF3);
        rd(1, 8'h00, "R9 status clear");

        // R12: set in the same cycle as a permitted clear wins
        rx_err_pulse = 1'b1; step(); rx_err_pulse = 1'b0;
        idle(1);
        rd(1, 8'h04, "R12 armed read");
        push(S_ERR, 1, 2, "R12 set wins");
        rx_err_pulse = 1'b1; bus_addr = 2'd1; bus_wdata = 8'hFB; bus_wr = 1'b1;
        step();
        rx_err_pulse = 1'b0; bus_wr = 1'b0;
        rd(1, 8'h04, "R12 flag kept");

        idle(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule